// File: doc/BRIEF.md
# ADC Control and Status Interface

This block is the digital front end of a successive-approximation ADC peripheral on a small microcontroller bus. Software writes the control register to choose one of four analog inputs. That write starts a conversion. The block then drives a start pulse and a divided clock-enable to an external converter core. When the core reports completion, the block captures its 8-bit result. It then either sets a completion flag or raises an interrupt request, depending on the interrupt-enable bit.

The block follows the processor's low-power states. In wait mode, conversions carry on, and a pending interrupt drives a wake request. In stop mode, the conversion in flight is dropped and the converter clock is gated. When stop ends, that conversion is relaunched. The first result after stop is tagged as settling. The all-ones channel code powers the converter down.

Top module: `adc_ctl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x1F, the data register (address 1) reads 0x00 and the clock register (address 2) reads 0x00; `irq` is low and `pwr_down` is high.
- R2: Control layout: bit 7 is the read-only completion flag, bit 6 enables interrupts, bit 5 selects continuous mode, bits 4:0 select the channel. A write with channel 0..3 clears the flag and the pending interrupt, and `conv_start` is high for exactly the one cycle after the write edge.
- R3: When the converter reports completion while interrupts are disabled, the result appears at address 1 and control bit 7 reads 1; `irq` stays low.
- R4: When interrupts are enabled, each completion raises `irq` in the cycle after `conv_done`, and control bit 7 reads 0.
- R5: Reading address 1 clears both the completion flag and `irq` at that read's clock edge.
- R6: Channel code 31 drives `pwr_down` high and aborts any conversion. While a code of 4 or more is held, no `conv_start` and no `conv_clk_en` occur, and a `conv_done` pulse is ignored.
- R7: With continuous mode set, `conv_start` pulses again in the cycle after each accepted completion. With it clear, no further start follows.
- R8: Clock register bits 2:0 give divide codes 0..4, and `conv_clk_en` pulses once every 1, 2, 4, 8 or 16 cycles while a conversion is active, counted from its start. Codes 5..7 divide by 1. The enable is low when no conversion is active.
- R9: Wait mode does not stop conversions; `wake` is high exactly while `irq` and `wait_mode` are both high.
- R10: While `stop_mode` is high, `conv_clk_en` is low, no new `conv_start` is issued, and `conv_done` is ignored.
- R11: If a conversion was active when stop was entered, `conv_start` pulses in the second cycle after `stop_mode` falls.
- R12: Clock register bit 7 reads 1 after the first result captured following a stop exit. The next result clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on address 1) |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wait_mode | input | 1 | Processor is in wait state |
| stop_mode | input | 1 | Processor is in stop state |
| conv_start | output | 1 | One-cycle launch pulse to the converter |
| conv_clk_en | output | 1 | Divided clock-enable to the converter |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 8 | Converter result, valid with `conv_done` |
| pwr_down | output | 1 | Converter power-down (channel code all ones) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request while in wait mode |

## Verification
The assertions assume three things about the inputs. `conv_done` is a single-cycle pulse. Register writes never land on the same edge as an accepted completion or a stop exit. A read of address 1 is not issued on the edge where a completion arrives. The stimulus keeps to this by waiting for each completion before it touches the bus. It also changes `stop_mode` only when no write is in flight. Completions that should be ignored are injected deliberately, and only while the block is powered down or stopped.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CHAN_W = 5;
    localparam int unsigned DIV_W  = 3;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_DAT = 2'd1;
    localparam logic [1:0] ADDR_CLK = 2'd2;

    localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

    typedef struct packed {
        logic              ien;
        logic              cont;
        logic [CHAN_W-1:0] chan;
        logic              done;
        logic              irq;
        logic [DATA_W-1:0] data;
        logic              unsettled;
        logic [DIV_W-1:0]  div;
    } regs_t;

    typedef struct packed {
        logic active;
        logic start;
        logic stop_seen;
        logic resume;
        logic settle;
    } seq_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              run,
    input  logic              restart,
    output logic              tick
);
    localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;
    int               shift;

    always_comb begin
        // out-of-range codes fall back to divide-by-1
        shift = (int'(code) <= MAX_LOG) ? int'(code) : 0;
        last  = CNT_W'((32'd1 << shift) - 32'd1);
        tick  = run && (cnt_q == last);
        if (!run || restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic halt,
    input  logic cont,
    input  logic chan_ok,
    input  logic stop_mode,
    input  logic conv_done,
    output logic conv_start,
    output logic active,
    output logic accept,
    output logic settle
);
    seq_t seq_d, seq_q;

    always_comb begin
        accept          = conv_done && seq_q.active && !stop_mode;
        seq_d           = seq_q;
        seq_d.start     = 1'b0;
        seq_d.stop_seen = stop_mode;

        if (stop_mode) begin
            // abort; remember whether work was in flight
            seq_d.active = 1'b0;
            if (seq_q.active) begin
                seq_d.resume = 1'b1;
            end
        end else if (seq_q.stop_seen) begin
            // first cycle out of stop
            seq_d.settle = 1'b1;
            seq_d.resume = 1'b0;
            if (seq_q.resume && chan_ok) begin
                seq_d.start  = 1'b1;
                seq_d.active = 1'b1;
            end
        end else if (launch) begin
            seq_d.start  = 1'b1;
            seq_d.active = 1'b1;
        end else if (halt) begin
            seq_d.active = 1'b0;
        end else if (accept) begin
            seq_d.settle = 1'b0;
            if (cont) begin
                seq_d.start = 1'b1;
            end else begin
                seq_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start = seq_q.start;
    assign active     = seq_q.active;
    assign settle     = seq_q.settle;
endmodule

// File: rtl/adc_ctl.sv
module adc_ctl
    import adc_ctl_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int MAX_DIV_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wait_mode,
    input  logic              stop_mode,
    output logic              conv_start,
    output logic              conv_clk_en,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              pwr_down,
    output logic              irq,
    output logic              wake
);
    localparam int    PAD_W    = DATA_W - 1 - DIV_W;
    localparam regs_t REGS_RST = '{ien: 1'b0, cont: 1'b0, chan: CHAN_OFF,
                                   done: 1'b0, irq: 1'b0, data: '0,
                                   unsettled: 1'b0, div: '0};

    regs_t st_d, st_q;
    logic  wr_ctl, wr_clk, rd_dat;
    logic  new_ok, chan_ok, launch, halt, run;
    logic  accept, settle, active;
    logic  unused_wbit;

    assign unused_wbit = bus_wdata[DATA_W-1];

    always_comb begin
        wr_ctl  = bus_wr && (bus_addr == ADDR_CTL);
        wr_clk  = bus_wr && (bus_addr == ADDR_CLK);
        rd_dat  = bus_rd && (bus_addr == ADDR_DAT);
        new_ok  = int'(bus_wdata[CHAN_W-1:0]) < NUM_CH;
        chan_ok = int'(st_q.chan) < NUM_CH;
        launch  = wr_ctl && new_ok && !stop_mode;
        halt    = wr_ctl && !new_ok && !stop_mode;
        run     = active && !stop_mode;

        st_d = st_q;
        if (wr_ctl) begin
            st_d.ien  = bus_wdata[CHAN_W+1];
            st_d.cont = bus_wdata[CHAN_W];
            st_d.chan = bus_wdata[CHAN_W-1:0];
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (wr_clk) begin
            st_d.div = bus_wdata[DIV_W-1:0];
        end
        if (rd_dat) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (accept) begin
            st_d.data      = conv_result;
            st_d.unsettled = settle;
            if (st_d.ien) begin
                st_d.irq = 1'b1;
            end else begin
                st_d.done = 1'b1;
            end
        end

        case (bus_addr)
            ADDR_CTL: bus_rdata = {st_q.done, st_q.ien, st_q.cont, st_q.chan};
            ADDR_DAT: bus_rdata = st_q.data;
            ADDR_CLK: bus_rdata = {st_q.unsettled, {PAD_W{1'b0}}, st_q.div};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= REGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    adc_conv_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .halt      (halt),
        .cont      (st_q.cont),
        .chan_ok   (chan_ok),
        .stop_mode (stop_mode),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .active    (active),
        .accept    (accept),
        .settle    (settle)
    );

    adc_clk_div #(
        .CODE_W (DIV_W),
        .MAX_LOG(MAX_DIV_LOG)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (st_q.div),
        .run    (run),
        .restart(wr_clk),
        .tick   (conv_clk_en)
    );

    assign pwr_down = (st_q.chan == CHAN_OFF);
    assign irq      = st_q.irq;
    assign wake     = st_q.irq && wait_mode;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_mode,
    input logic              conv_start,
    input logic              conv_clk_en,
    input logic              pwr_down,
    input logic              irq,
    input logic              wake,
    input logic              ien,
    input logic              done,
    input logic              rd_dat,
    input logic              accept,
    input logic [DATA_W-1:0] conv_result,
    input logic [DATA_W-1:0] data
);
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (data == $past(conv_result)));

    p_flag_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ien |-> !done);

    p_read_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && !accept) |=> !irq);

    p_pwrdn_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!conv_clk_en && !conv_start));

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);

    p_clk_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> !conv_clk_en);

    p_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> !conv_start);
endmodule

bind adc_ctl adc_ctl_chk #(.DATA_W(adc_ctl_pkg::DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_mode  (stop_mode),
    .conv_start (conv_start),
    .conv_clk_en(conv_clk_en),
    .pwr_down   (pwr_down),
    .irq        (irq),
    .wake       (wake),
    .ien        (st_q.ien),
    .done       (st_q.done),
    .rd_dat     (rd_dat),
    .accept     (accept),
    .conv_result(conv_result),
    .data       (st_q.data)
);

// File: tb/test_adc_ctl.sv
module test_adc_ctl;
    // 50 MHz: 20 time-unit period, unit taken as 1 ns
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wait_mode = 1'b0, stop_mode = 1'b0;
    logic       conv_start, conv_clk_en, pwr_down, irq, wake;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = 8'd0;

    int n_checks = 0;
    int n_fail   = 0;

    always #HALF clk = ~clk;

    adc_ctl i_adc_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wait_mode(wait_mode), .stop_mode(stop_mode),
        .conv_start(conv_start), .conv_clk_en(conv_clk_en),
        .conv_done(conv_done), .conv_result(conv_result),
        .pwr_down(pwr_down), .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int lim(input int code);
        return (code <= 4) ? (1 << code) : 1;
    endfunction

    // ---------------- converter stub ----------------
    int         inject_req = 0, inject_ack = 0;
    int         done_cnt = 0;
    int         s_n = 0;
    bit         s_busy = 0;
    logic [7:0] next_res = 8'h40;
    logic [7:0] last_res = 8'h00;

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (inject_req != inject_ack) begin
            inject_ack  = inject_req;
            conv_done   = 1'b1;
            conv_result = 8'hEE;
        end else if (stop_mode) begin
            s_busy = 0;
        end else if (conv_start) begin
            s_busy = 1;
            s_n    = 0;
        end else if (s_busy && conv_clk_en) begin
            s_n++;
            if (s_n == 3) begin
                s_busy      = 0;
                conv_done   = 1'b1;
                conv_result = next_res;
                last_res    = next_res;
                next_res    = next_res + 8'd7;
                done_cnt++;
            end
        end
    end

    // ---------------- reference model ----------------
    bit         m_ien, m_cont, m_done, m_irq, m_uns;
    bit         m_active, m_start, m_stopq, m_resume, m_settle;
    logic [4:0] m_chan;
    logic [7:0] m_data;
    logic [2:0] m_div;
    int         m_cnt;

    always @(posedge clk) begin : model
        bit wctl, wclk, rdd, nv, run, en, acc;
        bit nstart, nact, nres, nset;
        int ncnt;
        if (!rst_n) begin
            m_ien = 0; m_cont = 0; m_chan = 5'd31; m_done = 0; m_irq = 0;
            m_data = 8'd0; m_uns = 0; m_div = 3'd0; m_active = 0; m_start = 0;
            m_stopq = 0; m_resume = 0; m_settle = 0; m_cnt = 0;
        end else begin
            wctl = bus_wr && bus_addr == 2'd0;
            wclk = bus_wr && bus_addr == 2'd2;
            rdd  = bus_rd && bus_addr == 2'd1;
            nv   = bus_wdata[4:0] < 5'd4;
            run  = m_active && !stop_mode;
            en   = run && (m_cnt == lim(int'(m_div)) - 1);
            acc  = conv_done && m_active && !stop_mode;
            ncnt = (!run || wclk || en) ? 0 : (m_cnt + 1) % 16;

            nstart = 0; nact = m_active; nres = m_resume; nset = m_settle;
            if (stop_mode) begin
                nact = 0;
                if (m_active) nres = 1;
            end else if (m_stopq) begin
                nset = 1; nres = 0;
                if (m_resume && m_chan < 5'd4) begin nstart = 1; nact = 1; end
            end else if (wctl && nv) begin
                nstart = 1; nact = 1;
            end else if (wctl) begin
                nact = 0;
            end else if (acc) begin
                nset = 0;
                if (m_cont) nstart = 1; else nact = 0;
            end

            if (wctl) begin
                m_ien = bus_wdata[6]; m_cont = bus_wdata[5]; m_chan = bus_wdata[4:0];
                m_done = 0; m_irq = 0;
            end
            if (wclk) m_div = bus_wdata[2:0];
            if (rdd) begin m_done = 0; m_irq = 0; end
            if (acc) begin
                m_data = conv_result;
                m_uns  = m_settle;
                if (m_ien) m_irq = 1; else m_done = 1;
            end
            m_active = nact; m_start = nstart; m_resume = nres; m_settle = nset;
            m_stopq  = stop_mode; m_cnt = ncnt;
        end
    end

    always @(negedge clk) begin : compare
        logic [7:0] exp_rd;
        if (rst_n) begin
            case (bus_addr)
                2'd0:    exp_rd = {m_done, m_ien, m_cont, m_chan};
                2'd1:    exp_rd = m_data;
                2'd2:    exp_rd = {m_uns, 4'b0000, m_div};
                default: exp_rd = 8'h00;
            endcase
            check("R4", "irq", int'(irq), int'(m_irq));
            check("R9", "wake", int'(wake), int'(m_irq && wait_mode));
            check("R2", "conv_start", int'(conv_start), int'(m_start));
            check("R8", "conv_clk_en", int'(conv_clk_en),
                  int'(m_active && !stop_mode && m_cnt == lim(int'(m_div)) - 1));
            check("R6", "pwr_down", int'(pwr_down), int'(m_chan == 5'd31));
            check("R3 R12", "bus_rdata", int'(bus_rdata), int'(exp_rd));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic wait_done();
        int base;
        base = done_cnt;
        while (done_cnt == base) @(posedge clk);
        #2;
    endtask

    task automatic count_starts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) n++;
        end
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_clk_en) n++;
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_up();
    end

    // ---------------- stimulus ----------------
    initial begin : stim
        logic [7:0] v;
        int n;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, v); check("R1", "ctl after reset", v, 8'h1F);
        bus_read(2'd1, v); check("R1", "data after reset", v, 8'h00);
        bus_read(2'd2, v); check("R1", "clk after reset", v, 8'h00);
        check("R1", "irq after reset", irq, 0);
        check("R1", "pwr_down after reset", pwr_down, 1);

        // R2 / R3 / R5 / R7 single conversion, polled
        bus_write(2'd2, 8'h00);
        bus_write(2'd0, 8'h02);
        @(negedge clk); check("R2", "start pulse", conv_start, 1);
        @(negedge clk); check("R2", "start one cycle", conv_start, 0);
        wait_done();
        bus_read(2'd0, v); check("R3", "flag set", v, 8'h82);
        check("R3", "irq low when disabled", irq, 0);
        count_starts(20, n); check("R7", "single mode no restart", n, 0);
        bus_read(2'd1, v); check("R3", "result", v, last_res);
        bus_read(2'd0, v); check("R5", "flag cleared by read", v, 8'h02);

        // R4 / R9 / R5 interrupt mode, running in wait
        wait_mode = 1'b1;
        bus_write(2'd0, 8'h41);
        wait_done();
        @(negedge clk); check("R4", "irq raised", irq, 1);
        check("R9", "wake in wait", wake, 1);
        bus_read(2'd0, v); check("R4", "flag masked", v, 8'h41);
        bus_read(2'd1, v); check("R4", "result irq mode", v, last_res);
        @(negedge clk); check("R5", "irq acked", irq, 0);
        check("R9", "wake dropped", wake, 0);
        wait_mode = 1'b0;

        // R7 continuous mode, then R6 power down
        bus_write(2'd2, 8'h02);
        bus_write(2'd0, 8'h23);
        count_starts(150, n); check("R7", "continuous restarts", int'(n >= 3), 1);
        bus_write(2'd0, 8'h1F);
        @(negedge clk); check("R6", "pwr_down set", pwr_down, 1);
        count_ticks(20, n); check("R6", "no clk_en when off", n, 0);
        @(posedge clk); #2 inject_req++;
        repeat (3) @(posedge clk);
        bus_read(2'd0, v); check("R6", "done ignored when off", v, 8'h1F);
        check("R6", "no irq when off", irq, 0);
        bus_write(2'd0, 8'h05);
        @(negedge clk); check("R6", "code 5 not powered down", pwr_down, 0);
        count_starts(10, n); check("R6", "code 5 no start", n, 0);

        // R8 divider codes
        for (int c = 0; c < 8; c++) begin
            bus_write(2'd0, 8'h1F);
            bus_write(2'd2, 8'(c));
            bus_write(2'd0, 8'h20);
            count_ticks(32, n);
            check("R8", $sformatf("ticks code %0d", c), n, 32 / lim(c));
        end

        // R10 / R11 / R12 stop handling
        bus_write(2'd0, 8'h1F);
        bus_write(2'd2, 8'h03);
        bus_write(2'd0, 8'h00);
        repeat (4) @(posedge clk);
        #2 stop_mode = 1'b1;
        count_ticks(12, n); check("R10", "no clk_en in stop", n, 0);
        @(posedge clk); #2 inject_req++;
        repeat (3) @(posedge clk);
        bus_read(2'd0, v); check("R10", "done ignored in stop", v, 8'h00);
        count_starts(4, n); check("R10", "no start in stop", n, 0);
        @(posedge clk); #2 stop_mode = 1'b0;
        @(negedge clk); check("R11", "no start in exit cycle", conv_start, 0);
        @(negedge clk); check("R11", "restart after stop", conv_start, 1);
        wait_done();
        bus_read(2'd2, v); check("R12", "settling flag set", v, 8'h83);
        bus_read(2'd1, v); check("R12", "first result after stop", v, last_res);
        bus_write(2'd0, 8'h00);
        wait_done();
        bus_read(2'd2, v); check("R12", "settling flag cleared", v, 8'h03);

        repeat (5) @(posedge clk);
        finish_up();
    end
endmodule